// File: doc/BRIEF.md
# Collision-Free Instruction Planner

This block sits where several independent instruction pipelines meet a shared data-movement engine. Each cycle it looks at a set of candidate instructions. Every instruction moves one data block and names a source row, a destination row and a one-bit color. The block grants a subset of these in which no source row and no destination row is used twice. Each granted instruction is handed off through its own valid/ready pair. An instruction that is not granted stays asserted at its input and competes again in the following cycle.

The planner serves one color at a time, which makes the grants proceed in epochs. Instructions that carry the other color wait until the color switches, so no instruction can be starved by newer traffic. The end of an epoch is found with an idle timer. The timer is reloaded whenever a new-transaction notice arrives or a matching instruction is waiting. When it runs out with nothing of the current color left, the planner flips its color and, after a configurable delay, emits a one-cycle confirmation that names the color just finished. Upstream logic uses that pulse to release completions in order.

Top module: `planner_core`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `acceptColor` is 0, `confirmValid` is 0 and no `instReady` bit is set while no instruction is valid.
- R2: Two instructions that are ready in the same cycle never carry the same source row.
- R3: Two instructions that are ready in the same cycle never carry the same destination row.
- R4: An instruction is ready only if its valid bit is 1 and its color bit equals `acceptColor`. An instruction of the other color is never ready.
- R5: Priority runs by index, with index 0 the highest. Instruction i is ready exactly when it matches the color and no lower-index ready instruction shares its source row or its destination row. A losing instruction is therefore granted once its blocker is withdrawn.
- R6: A clock edge is active when `newTrans` is 1 or any valid instruction matches `acceptColor`. `acceptColor` toggles on the 2^TMO_W-th clock edge after the last active edge, provided no active edge occurs in between.
- R7: `confirmValid` is a one-cycle pulse. It is raised CONF_DELAY-1 clock edges after the edge on which `acceptColor` toggles, on that same edge when CONF_DELAY is 1. While it is high, `confirmColor` holds the color value that was in force before the toggle.
- R8: A `newTrans` pulse with no valid instructions present restarts the idle timer, so the toggle comes 2^TMO_W edges after that pulse and not earlier.
- R9: Valid instructions of the other color do not keep an epoch open. With only such instructions present, the toggle still comes 2^TMO_W edges after the last active edge, and those instructions are granted after the toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | NUM_INST | Valid flag of each candidate instruction |
| instColor | input | NUM_INST | Color bit of each candidate instruction |
| instSrcRow | input | NUM_INST x log2(SRC_ROWS) | Source row of each candidate instruction |
| instDstRow | input | NUM_INST x log2(DST_ROWS) | Destination row of each candidate instruction |
| newTrans | input | 1 | Notice that a new transaction has entered upstream |
| instReady | output | NUM_INST | Grant, one bit per instruction, high only in the cycle of acceptance |
| acceptColor | output | 1 | Color currently being served |
| confirmValid | output | 1 | Delayed one-cycle epoch-complete pulse |
| confirmColor | output | 1 | Color whose epoch has completed, valid with confirmValid |

## Verification
The bench builds the block with four instruction slots, four source rows, four destination rows, a 3-bit idle timer and a two-stage confirmation delay. With four slots and four rows, several thousand generated patterns reach every kind of collision: chains in which a losing slot stops blocking higher indices, clashes on both the source row and the destination row, and mixed colors. Every pattern is compared against an arithmetic greedy model. The short timer lets the bench count exact eight-edge windows until the toggle after idle periods, after notice pulses and while only other-color work is waiting, and it checks the delayed confirmation pulse and the color it carries.

// File: rtl/planner_pkg.sv
package planner_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptColor;
  } ctrlStrobe_t;

  // summary from datapath to control
  typedef struct packed {
    logic anyMatch;
  } dpStatus_t;

endpackage

// File: rtl/planner_select.sv
module planner_select
  import planner_pkg::*;
#(
  parameter int NUM_INST = 4,
  parameter int SRC_W    = 2,
  parameter int DST_W    = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  ctrlStrobe_t                    ctrl,
  input  logic [NUM_INST-1:0]            instValid,
  input  logic [NUM_INST-1:0]            instColor,
  input  logic [NUM_INST-1:0][SRC_W-1:0] instSrcRow,
  input  logic [NUM_INST-1:0][DST_W-1:0] instDstRow,
  output logic [NUM_INST-1:0]            grant,
  output dpStatus_t                      status
);

  logic [NUM_INST-1:0] matchVec;

  // color filter
  generate
    for (genvar i = 0; i < NUM_INST; i++) begin : g_match
      assign matchVec[i] = instValid[i] && (instColor[i] == ctrl.acceptColor);
    end
  endgenerate

  // greedy fixed-priority selection: lower index wins, losers do not block
  always_comb begin
    logic [NUM_INST-1:0] gv;
    logic                blocked;
    gv = '0;
    for (int i = 0; i < NUM_INST; i++) begin
      blocked = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (gv[j] && ((instSrcRow[j] == instSrcRow[i]) ||
                      (instDstRow[j] == instDstRow[i])))
          blocked = 1'b1;
      end
      gv[i] = matchVec[i] && !blocked;
    end
    grant = gv;
  end

  assign status.anyMatch = |matchVec;

  // pairwise collision guards
  generate
    for (genvar a = 0; a < NUM_INST; a++) begin : g_pa
      for (genvar b = a + 1; b < NUM_INST; b++) begin : g_pb
        p_src_unique_r2: assert property (@(posedge clk) disable iff (rst)
          !(grant[a] && grant[b] && (instSrcRow[a] == instSrcRow[b])));
        p_dst_unique_r3: assert property (@(posedge clk) disable iff (rst)
          !(grant[a] && grant[b] && (instDstRow[a] == instDstRow[b])));
      end
    end
    for (genvar k = 0; k < NUM_INST; k++) begin : g_pc
      p_grant_color_r4: assert property (@(posedge clk) disable iff (rst)
        grant[k] |-> (instValid[k] && (instColor[k] == ctrl.acceptColor)));
    end
  endgenerate

endmodule

// File: rtl/planner_ctrl.sv
module planner_ctrl
  import planner_pkg::*;
#(
  parameter int TMO_W      = 3,
  parameter int CONF_DELAY = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        newTrans,
  input  dpStatus_t   status,
  output ctrlStrobe_t ctrl,
  output logic        confirmValid,
  output logic        confirmColor
);

  localparam logic [TMO_W-1:0] TMO_MAX = {TMO_W{1'b1}};

  logic [TMO_W-1:0]      tmoCnt;
  logic                  curColor;
  logic                  epochEnd;
  logic [CONF_DELAY-1:0] confV;
  logic [CONF_DELAY-1:0] confC;

  assign epochEnd = !newTrans && !status.anyMatch && (tmoCnt == '0);

  // idle timer and accepting color
  always_ff @(posedge clk) begin
    if (rst) begin
      tmoCnt   <= TMO_MAX;
      curColor <= 1'b0;
    end else if (newTrans || status.anyMatch) begin
      tmoCnt <= TMO_MAX;
    end else if (epochEnd) begin
      tmoCnt   <= TMO_MAX;
      curColor <= !curColor;
    end else begin
      tmoCnt <= tmoCnt - 1'b1;
    end
  end

  // confirmation delay line
  always_ff @(posedge clk) begin
    if (rst) begin
      confV <= '0;
      confC <= '0;
    end else begin
      confV[0] <= epochEnd;
      confC[0] <= curColor;
      for (int k = 1; k < CONF_DELAY; k++) begin
        confV[k] <= confV[k-1];
        confC[k] <= confC[k-1];
      end
    end
  end

  assign ctrl.acceptColor = curColor;
  assign confirmValid     = confV[CONF_DELAY-1];
  assign confirmColor     = confC[CONF_DELAY-1];

  p_flip_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(curColor) |-> $past(!status.anyMatch && !newTrans));
  p_notice_holds_r8: assert property (@(posedge clk) disable iff (rst)
    newTrans |=> $stable(curColor));
  p_conf_single_r7: assert property (@(posedge clk) disable iff (rst)
    confirmValid |=> !confirmValid);

endmodule

// File: rtl/planner_core.sv
module planner_core
  import planner_pkg::*;
#(
  parameter int NUM_INST   = 4,
  parameter int SRC_ROWS   = 4,
  parameter int DST_ROWS   = 4,
  parameter int TMO_W      = 3,
  parameter int CONF_DELAY = 2,
  localparam int SRC_W     = (SRC_ROWS > 1) ? $clog2(SRC_ROWS) : 1,
  localparam int DST_W     = (DST_ROWS > 1) ? $clog2(DST_ROWS) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_INST-1:0]            instValid,
  input  logic [NUM_INST-1:0]            instColor,
  input  logic [NUM_INST-1:0][SRC_W-1:0] instSrcRow,
  input  logic [NUM_INST-1:0][DST_W-1:0] instDstRow,
  input  logic                           newTrans,
  output logic [NUM_INST-1:0]            instReady,
  output logic                           acceptColor,
  output logic                           confirmValid,
  output logic                           confirmColor
);

  ctrlStrobe_t ctrlS;
  dpStatus_t   dpS;

  planner_ctrl #(
    .TMO_W      (TMO_W),
    .CONF_DELAY (CONF_DELAY)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .newTrans     (newTrans),
    .status       (dpS),
    .ctrl         (ctrlS),
    .confirmValid (confirmValid),
    .confirmColor (confirmColor)
  );

  planner_select #(
    .NUM_INST (NUM_INST),
    .SRC_W    (SRC_W),
    .DST_W    (DST_W)
  ) u_sel (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrlS),
    .instValid  (instValid),
    .instColor  (instColor),
    .instSrcRow (instSrcRow),
    .instDstRow (instDstRow),
    .grant      (instReady),
    .status     (dpS)
  );

  assign acceptColor = ctrlS.acceptColor;

  p_top_first_r5: assert property (@(posedge clk) disable iff (rst)
    (instValid[0] && (instColor[0] == acceptColor)) |-> instReady[0]);
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!acceptColor && !confirmValid));

endmodule

// File: tb/sim_planner_core.sv
`timescale 1ns/1ps
module sim_planner_core;

  localparam int N     = 4;
  localparam int SW    = 2;
  localparam int DW    = 2;
  localparam int TW    = 3;
  localparam int CD    = 2;
  localparam int IDLE  = 1 << TW;

  logic              clk = 1'b0;
  logic              rst;
  logic [N-1:0]      instValid, instColor, instReady;
  logic [N-1:0][SW-1:0] instSrcRow;
  logic [N-1:0][DW-1:0] instDstRow;
  logic              newTrans, acceptColor, confirmValid, confirmColor;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  planner_core #(.NUM_INST(N), .SRC_ROWS(4), .DST_ROWS(4),
                 .TMO_W(TW), .CONF_DELAY(CD)) u0 (
    .clk(clk), .rst(rst), .instValid(instValid), .instColor(instColor),
    .instSrcRow(instSrcRow), .instDstRow(instDstRow), .newTrans(newTrans),
    .instReady(instReady), .acceptColor(acceptColor),
    .confirmValid(confirmValid), .confirmColor(confirmColor));

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model(input logic col);
    logic [N-1:0] g = '0;
    for (int i = 0; i < N; i++) begin
      logic blk = 1'b0;
      for (int j = 0; j < i; j++)
        if (g[j] && (instSrcRow[j] == instSrcRow[i] || instDstRow[j] == instDstRow[i]))
          blk = 1'b1;
      g[i] = instValid[i] && (instColor[i] == col) && !blk;
    end
    return g;
  endfunction

  function automatic logic [31:0] nextRnd(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  // count edges until the color toggles
  task automatic waitToggle(output int n);
    logic old = acceptColor;
    n = 0;
    while (n < 60) begin
      @(posedge clk); #1;
      n++;
      if (acceptColor != old) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish();
  end

  initial begin
    int n;
    logic oldC;
    rst = 1; instValid = '0; instColor = '0; instSrcRow = '0; instDstRow = '0; newTrans = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 color in reset", acceptColor, 0);
    check("R1 confirm in reset", confirmValid, 0);
    @(negedge clk); rst = 0; #1;
    check("R1 color", acceptColor, 0);
    check("R1 ready", instReady, 0);
    check("R1 confirm", confirmValid, 0);

    // R5 source clash, then retry after withdrawal
    @(negedge clk);
    instColor = {N{acceptColor}};
    instValid = 4'b0011;
    instSrcRow[0] = 1; instSrcRow[1] = 1; instDstRow[0] = 0; instDstRow[1] = 2;
    #1 check("R5 src clash low wins", instReady, 4'b0001);
    @(negedge clk); instValid = 4'b0010;
    #1 check("R5 loser retried", instReady, 4'b0010);
    // R3 destination clash
    @(negedge clk);
    instColor = {N{acceptColor}};
    instValid = 4'b1100;
    instSrcRow[2] = 0; instSrcRow[3] = 3; instDstRow[2] = 1; instDstRow[3] = 1;
    #1 check("R3 dst clash", instReady, 4'b0100);
    // R5 loser does not block higher index
    @(negedge clk);
    instColor = {N{acceptColor}};
    instValid = 4'b0111;
    instSrcRow[0] = 0; instDstRow[0] = 0;
    instSrcRow[1] = 0; instDstRow[1] = 1;
    instSrcRow[2] = 1; instDstRow[2] = 1;
    #1 check("R5 chain", instReady, 4'b0101);

    // R2 R3 R4 R5 sweep
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      seed = nextRnd(seed);
      instValid  = seed[3:0];
      instColor  = (k % 4 == 0) ? seed[7:4] : {N{acceptColor}};
      instSrcRow = seed[15:8];
      instDstRow = seed[23:16];
      newTrans   = seed[24];
      #1;
      check("R5 sweep grant", instReady, model(acceptColor));
      for (int a = 0; a < N; a++) begin
        if (instReady[a] && instColor[a] != acceptColor)
          check("R4 color", 1, 0);
        for (int b = a + 1; b < N; b++) begin
          if (instReady[a] && instReady[b] && instSrcRow[a] == instSrcRow[b])
            check("R2 src unique", 1, 0);
          if (instReady[a] && instReady[b] && instDstRow[a] == instDstRow[b])
            check("R3 dst unique", 1, 0);
        end
      end
    end

    // R6 / R7 idle timeout and confirmation
    @(negedge clk); instValid = '0; newTrans = 1;
    @(negedge clk); newTrans = 0;
    oldC = acceptColor;
    waitToggle(n);
    check("R6 idle edges", n, IDLE);
    check("R6 toggled", acceptColor, !oldC);
    if (CD > 1) begin
      check("R7 not early", confirmValid, 0);
      repeat (CD - 1) @(posedge clk);
      #1;
    end
    check("R7 confirm pulse", confirmValid, 1);
    check("R7 confirm color", confirmColor, oldC);
    @(posedge clk); #1;
    check("R7 one cycle", confirmValid, 0);

    // R8 notice restarts timer
    @(negedge clk); newTrans = 1;
    @(negedge clk); newTrans = 0;
    repeat (4) @(negedge clk);
    newTrans = 1;
    @(negedge clk); newTrans = 0;
    waitToggle(n);
    check("R8 notice reload", n, IDLE);

    // R9 other-color work does not hold epoch
    @(negedge clk);
    newTrans = 1;
    instValid = 4'b1111;
    instColor = {N{!acceptColor}};
    instSrcRow = 8'b11_10_01_00; instDstRow = 8'b00_01_10_11;
    #1 check("R4 other color held", instReady, 0);
    @(negedge clk); newTrans = 0;
    waitToggle(n);
    check("R9 toggle with foreign", n, IDLE);
    #1 check("R9 granted after toggle", instReady, 4'b1111);

    @(negedge clk); instValid = '0;
    finish();
  end

endmodule